// File: doc/BRIEF.md
# Folded 64-Point Radix-4 FFT Engine

This block computes a 64-point complex discrete Fourier transform, forward or inverse, with a single radix-4 butterfly reused over 48 consecutive cycles. The whole frame sits in one register vector. On each cycle the butterfly reads four adjacent vector slots, forms the four radix-4 outputs, rotates three of them by twiddle factors, and writes them back into the same slots. A 6-bit step counter drives the schedule. Its upper two bits select the stage (0 to 2) and its lower four bits select the group (0 to 15). On the step that finishes group 15 of a stage, the whole vector is also reordered by that stage's fixed permutation. This places the digit to be combined next in the lowest position.

Samples are written one at a time through a load port while the engine is idle. Loading places each sample at its slot for the first stage. A start pulse then launches the 48 steps, and the direction is sampled on that same pulse. After the final permutation the vector holds the spectrum in natural bin order, and it can be read through a combinational read port. The twiddle table is computed at elaboration from the twiddle width. The data path carries seven guard bits above the input width, so no scaling is applied and no overflow is possible.

Top module: `fft64_fold_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, busy and done are 0, and every vector slot reads back as zero.
- R2: A load strobe while busy is high has no effect on the frame being transformed or on its result.
- R3: A start strobe while idle sets busy on the next cycle and latches the direction input (0 = forward, 1 = inverse). A start strobe while busy is ignored and does not lengthen the run.
- R4: With direction 0, reading out_idx = k after the run returns X[k] = sum over n of x[n]·exp(-2πi·nk/64), where x[n] was loaded at load_idx = n. The error is within a few LSB, set by the twiddle width.
- R5: With direction 1, the result is sum over n of x[n]·exp(+2πi·nk/64), with no division by 64, and the same tolerance applies.
- R6: busy stays high for exactly 48 clock cycles per run. done is a single-cycle pulse in the first cycle after busy falls.
- R7: An impulse at index 0 yields that exact value in every bin, because only unit twiddles touch non-zero data.
- R8: The outputs are IN_W+7 bits wide. A constant full-scale input of +2047 or of -2048 on both real and imaginary parts gives exactly 64 times that value in bin 0 and zero in the other bins.
- R9: While idle with no load and no start, the stored result stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Write one input sample (accepted only when idle) |
| load_idx | input | 6 | Time index n of the sample |
| load_re | input | IN_W | Real part of the sample, signed |
| load_im | input | IN_W | Imaginary part of the sample, signed |
| start | input | 1 | Begin a transform (accepted only when idle) |
| inverse | input | 1 | Direction, sampled with start: 0 forward, 1 inverse |
| busy | output | 1 | High during the 48 butterfly steps |
| done | output | 1 | One-cycle pulse after the last step |
| out_idx | input | 6 | Frequency bin to read |
| out_re | output | IN_W+7 | Real part of the selected bin, signed |
| out_im | output | IN_W+7 | Imaginary part of the selected bin, signed |

## Verification
Impulses at index 0 and at constant inputs isolate the slot ordering and guard-bit handling, because these results must be exact. Impulses at indices 5 and 63 expose every twiddle angle in turn, since their output phase steps through all exponents. Complex tones put the energy into one bin, so a swapped permutation or a wrong stage exponent shows up as energy in the wrong bin. Full-scale pseudo-random frames in both directions exercise every butterfly path at once and separate a sign or conjugation slip in the inverse path from a fault in the forward path.

// File: rtl/fft_fold_pkg.sv
package fft_fold_pkg;

   localparam int NPTS   = 64;
   localparam int RADIX  = 4;
   localparam int NSTAGE = 3;
   localparam int NGRP   = NPTS / RADIX;
   localparam int NSTEP  = NSTAGE * NGRP;
   localparam int IDX_W  = $clog2(NPTS);
   localparam int GUARD  = 7;

   // Slot used for time sample n: base-4 digits (a,b,c) go to (b,c,a),
   // so that the first stage combines the most significant digit.
   function automatic logic [5:0] load_slot(input logic [5:0] n);
      return {n[3:2], n[1:0], n[5:4]};
   endfunction

   // Source slot feeding slot p in the reorder that closes a stage.
   // Stage 1 exchanges the two low digits; stages 0 and 2 exchange
   // the outer digits. Both are involutions.
   function automatic logic [5:0] perm_src(input logic [1:0] st,
                                           input logic [5:0] p);
      if (st == 2'd1) return {p[5:4], p[1:0], p[3:2]};
      return {p[1:0], p[3:2], p[5:4]};
   endfunction

   // Twiddle exponent step for a group; output k of the butterfly
   // is rotated by W64^(base*k).
   function automatic logic [5:0] tw_base(input logic [1:0] st,
                                          input logic [3:0] g);
      case (st)
         2'd0:    return {2'b00, g};
         2'd1:    return {2'b00, g[1:0], 2'b00};
         default: return 6'd0;
      endcase
   endfunction

endpackage

// File: rtl/fft_step_ctrl.sv
module fft_step_ctrl #(
   parameter int STEPS = 48
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       inverse,
   output logic       busy,
   output logic       done,
   output logic [5:0] step,
   output logic       inv_q
);
   localparam logic [5:0] LAST = 6'(STEPS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         step  <= 6'd0;
         inv_q <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy  <= 1'b1;
               step  <= 6'd0;
               inv_q <= inverse;
            end
         end else if (step == LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
            step <= 6'd0;
         end else begin
            step <= step + 6'd1;
         end
      end
   end
endmodule

// File: rtl/fft_twiddle_rom.sv
module fft_twiddle_rom #(
   parameter int TW_W = 16
) (
   input  logic                   inv,
   input  logic [5:0]             expo [3],
   output logic signed [TW_W-1:0] tw_re [3],
   output logic signed [TW_W-1:0] tw_im [3]
);
   localparam int  FRAC  = TW_W - 2;
   localparam real SCALE = 2.0 ** FRAC;
   localparam real TWO_PI = 6.283185307179586;

   logic signed [TW_W-1:0] tab_re [64];
   logic signed [TW_W-1:0] tab_im [64];

   // Forward table: W64^i = cos(2*pi*i/64) - j*sin(2*pi*i/64)
   for (genvar i = 0; i < 64; i++) begin : g_ent
      localparam real ANG = TWO_PI * i / 64.0;
      localparam real CR  = $cos(ANG) * SCALE;
      localparam real CI  = -$sin(ANG) * SCALE;
      localparam int  CRI = $rtoi(CR >= 0.0 ? CR + 0.5 : CR - 0.5);
      localparam int  CII = $rtoi(CI >= 0.0 ? CI + 0.5 : CI - 0.5);
      assign tab_re[i] = TW_W'(CRI);
      assign tab_im[i] = TW_W'(CII);
   end

   always_comb begin
      for (int k = 0; k < 3; k++) begin
         tw_re[k] = tab_re[expo[k]];
         tw_im[k] = inv ? -tab_im[expo[k]] : tab_im[expo[k]];
      end
   end
endmodule

// File: rtl/fft_bfly4.sv
module fft_bfly4 #(
   parameter int DW       = 19,
   parameter int TW_W     = 16,
   parameter bit ROUND_TW = 1'b1
) (
   input  logic                   inv,
   input  logic signed [DW-1:0]   ar [4],
   input  logic signed [DW-1:0]   ai [4],
   input  logic signed [TW_W-1:0] twr [3],
   input  logic signed [TW_W-1:0] twi [3],
   output logic signed [DW-1:0]   br [4],
   output logic signed [DW-1:0]   bi [4]
);
   localparam int SW   = DW + 2;
   localparam int PW   = DW + TW_W + 1;
   localparam int FRAC = TW_W - 2;

   logic signed [SW-1:0] xr [4];
   logic signed [SW-1:0] xi [4];
   logic signed [SW-1:0] yr [4];
   logic signed [SW-1:0] yi [4];
   logic signed [SW-1:0] pr, pi, qr, qi;
   logic signed [PW-1:0] bias;

   always_comb begin
      for (int j = 0; j < 4; j++) begin
         xr[j] = SW'(ar[j]);
         xi[j] = SW'(ai[j]);
      end
      pr = xr[0] - xr[2];
      pi = xi[0] - xi[2];
      qr = xr[1] - xr[3];
      qi = xi[1] - xi[3];
      yr[0] = xr[0] + xr[1] + xr[2] + xr[3];
      yi[0] = xi[0] + xi[1] + xi[2] + xi[3];
      yr[2] = xr[0] - xr[1] + xr[2] - xr[3];
      yi[2] = xi[0] - xi[1] + xi[2] - xi[3];
      // forward: y1 = p - jq, y3 = p + jq; inverse swaps them
      if (!inv) begin
         yr[1] = pr + qi;  yi[1] = pi - qr;
         yr[3] = pr - qi;  yi[3] = pi + qr;
      end else begin
         yr[1] = pr - qi;  yi[1] = pi + qr;
         yr[3] = pr + qi;  yi[3] = pi - qr;
      end
   end

   if (ROUND_TW) begin : g_round
      assign bias = PW'(1) <<< (FRAC - 1);
   end else begin : g_trunc
      assign bias = '0;
   end

   assign br[0] = DW'(yr[0]);
   assign bi[0] = DW'(yi[0]);

   for (genvar k = 1; k < 4; k++) begin : g_rot
      logic signed [DW-1:0] ur, ui;
      logic signed [PW-1:0] mr, mi;
      assign ur = DW'(yr[k]);
      assign ui = DW'(yi[k]);
      assign mr = PW'(ur) * PW'(twr[k-1]) - PW'(ui) * PW'(twi[k-1]) + bias;
      assign mi = PW'(ur) * PW'(twi[k-1]) + PW'(ui) * PW'(twr[k-1]) + bias;
      assign br[k] = DW'(mr >>> FRAC);
      assign bi[k] = DW'(mi >>> FRAC);
   end
endmodule

// File: rtl/fft64_fold_engine.sv
module fft64_fold_engine #(
   parameter int IN_W     = 12,
   parameter int TW_W     = 16,
   parameter bit ROUND_TW = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_en,
   input  logic [5:0]           load_idx,
   input  logic signed [IN_W-1:0] load_re,
   input  logic signed [IN_W-1:0] load_im,
   input  logic                 start,
   input  logic                 inverse,
   output logic                 busy,
   output logic                 done,
   input  logic [5:0]           out_idx,
   output logic signed [IN_W+6:0] out_re,
   output logic signed [IN_W+6:0] out_im
);
   localparam int DW = IN_W + fft_fold_pkg::GUARD;
   localparam int NP = fft_fold_pkg::NPTS;

   if (IN_W < 4 || IN_W > 24) begin : g_bad_in_w
      $error("fft64_fold_engine: IN_W must lie in 4..24");
   end
   if (TW_W < 8 || TW_W > 24) begin : g_bad_tw_w
      $error("fft64_fold_engine: TW_W must lie in 8..24");
   end

   logic [5:0] step;
   logic       inv_q;
   logic [1:0] stage;
   logic [3:0] grp;

   fft_step_ctrl #(.STEPS(fft_fold_pkg::NSTEP)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .inverse (inverse),
      .busy    (busy),
      .done    (done),
      .step    (step),
      .inv_q   (inv_q)
   );

   assign stage = step[5:4];
   assign grp   = step[3:0];

   logic signed [DW-1:0] vr [NP];
   logic signed [DW-1:0] vi [NP];
   logic signed [DW-1:0] ar [4];
   logic signed [DW-1:0] ai [4];
   logic signed [DW-1:0] br [4];
   logic signed [DW-1:0] bi [4];
   logic signed [DW-1:0] tr [NP];
   logic signed [DW-1:0] ti [NP];
   logic signed [DW-1:0] nr [NP];
   logic signed [DW-1:0] ni [NP];
   logic [5:0]           base;
   logic [5:0]           expo [3];
   logic signed [TW_W-1:0] twr [3];
   logic signed [TW_W-1:0] twi [3];

   always_comb begin
      for (int j = 0; j < 4; j++) begin
         ar[j] = vr[{grp, 2'(j)}];
         ai[j] = vi[{grp, 2'(j)}];
      end
   end

   assign base    = fft_fold_pkg::tw_base(stage, grp);
   assign expo[0] = base;
   assign expo[1] = base << 1;
   assign expo[2] = base + (base << 1);

   fft_twiddle_rom #(.TW_W(TW_W)) u_rom (
      .inv   (inv_q),
      .expo  (expo),
      .tw_re (twr),
      .tw_im (twi)
   );

   fft_bfly4 #(.DW(DW), .TW_W(TW_W), .ROUND_TW(ROUND_TW)) u_bfly (
      .inv (inv_q),
      .ar  (ar),
      .ai  (ai),
      .twr (twr),
      .twi (twi),
      .br  (br),
      .bi  (bi)
   );

   // write back the group, then reorder the whole vector after group 15
   always_comb begin
      for (int p = 0; p < NP; p++) begin
         if (p[5:2] == grp) begin
            tr[p] = br[p[1:0]];
            ti[p] = bi[p[1:0]];
         end else begin
            tr[p] = vr[p];
            ti[p] = vi[p];
         end
      end
      for (int p = 0; p < NP; p++) begin
         if (grp == 4'd15) begin
            nr[p] = tr[fft_fold_pkg::perm_src(stage, 6'(p))];
            ni[p] = ti[fft_fold_pkg::perm_src(stage, 6'(p))];
         end else begin
            nr[p] = tr[p];
            ni[p] = ti[p];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < NP; p++) begin
            vr[p] <= '0;
            vi[p] <= '0;
         end
      end else if (busy) begin
         for (int p = 0; p < NP; p++) begin
            vr[p] <= nr[p];
            vi[p] <= ni[p];
         end
      end else if (load_en) begin
         vr[fft_fold_pkg::load_slot(load_idx)] <= DW'(load_re);
         vi[fft_fold_pkg::load_slot(load_idx)] <= DW'(load_im);
      end
   end

   assign out_re = vr[out_idx];
   assign out_im = vi[out_idx];
endmodule

// File: rtl/fft_fold_chk.sv
module fft_fold_chk #(
   parameter int IN_W = 12,
   parameter int DW   = IN_W + 7
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start,
   input logic                 load_en,
   input logic                 busy,
   input logic                 done,
   input logic [5:0]           out_idx,
   input logic signed [DW-1:0] out_re,
   input logic signed [DW-1:0] out_im
);
   logic [6:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= 7'd0;
      else if (busy) run_len <= run_len + 7'd1;
      else           run_len <= 7'd0;
   end

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (!busy && !done));

   assert_start_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   assert_run_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len == 7'd48));

   assert_run_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_len < 7'd48));

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !load_en && !start) |=>
         ($stable(out_idx) -> ($stable(out_re) && $stable(out_im))));
endmodule

bind fft64_fold_engine fft_fold_chk #(.IN_W(IN_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .load_en (load_en),
   .busy    (busy),
   .done    (done),
   .out_idx (out_idx),
   .out_re  (out_re),
   .out_im  (out_im)
);

// File: tb/sim_fft64_fold_engine.sv
module sim_fft64_fold_engine;
   localparam int IN_W = 12;
   localparam int DW   = IN_W + 7;
   localparam int NF   = 9;
   // kind (0 impulse, 1 constant, 2 tone, 3 random), param, amp, inverse, tol
   localparam int VEC [NF][5] = '{
      '{0,     0,  1000, 0,  0},
      '{0,     5,  1500, 0,  4},
      '{1,     0,  2047, 0,  0},
      '{1, -2048, -2048, 0,  0},
      '{2,     3,  1000, 0, 32},
      '{3,     1,  2047, 0, 48},
      '{3,     2,  2047, 1, 48},
      '{2,     7,   900, 1, 32},
      '{0,    63,  1200, 1,  4}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic load_en = 1'b0;
   logic [5:0] load_idx = '0;
   logic signed [IN_W-1:0] load_re = '0;
   logic signed [IN_W-1:0] load_im = '0;
   logic start = 1'b0;
   logic inverse = 1'b0;
   logic busy, done;
   logic [5:0] out_idx = '0;
   logic signed [DW-1:0] out_re, out_im;

   int errors = 0;
   int checks = 0;
   int in_re [64];
   int in_im [64];
   int got_re [64];
   int got_im [64];

   always #4 clk = ~clk;

   fft64_fold_engine u0 (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
      .load_re(load_re), .load_im(load_im), .start(start), .inverse(inverse),
      .busy(busy), .done(done), .out_idx(out_idx), .out_re(out_re), .out_im(out_im)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic string tag_of(input int i);
      case (i)
         0:       return "R7";
         2, 3:    return "R8";
         6, 7, 8: return "R5";
         default: return "R4";
      endcase
   endfunction

   task automatic make_frame(input int kind, input int param, input int amp);
      for (int n = 0; n < 64; n++) begin
         real ang;
         int unsigned h;
         in_re[n] = 0;
         in_im[n] = 0;
         case (kind)
            0: if (n == param) in_re[n] = amp;
            1: begin in_re[n] = amp; in_im[n] = param; end
            2: begin
               ang = 6.283185307179586 * ((param * n) % 64) / 64.0;
               in_re[n] = $rtoi(amp * $cos(ang));
               in_im[n] = $rtoi(amp * $sin(ang));
            end
            default: begin
               h = (32'(n) + 32'd1) * 32'd2654435761 ^ (32'(param) * 32'd40503);
               h = h ^ (h >> 15);
               h = h * 32'd2246822519;
               h = h ^ (h >> 13);
               in_re[n] = int'(h % 32'd4095) - 2047;
               in_im[n] = int'((h >> 12) % 32'd4095) - 2047;
            end
         endcase
      end
   endtask

   task automatic load_frame();
      for (int n = 0; n < 64; n++) begin
         @(negedge clk);
         load_en  = 1'b1;
         load_idx = 6'(n);
         load_re  = IN_W'(in_re[n]);
         load_im  = IN_W'(in_im[n]);
      end
      @(negedge clk);
      load_en = 1'b0;
   endtask

   task automatic read_all();
      for (int k = 0; k < 64; k++) begin
         @(negedge clk);
         out_idx = 6'(k);
         #1;
         got_re[k] = int'(out_re);
         got_im[k] = int'(out_im);
      end
   endtask

   function automatic int frame_err(input bit inv_m);
      int worst = 0;
      for (int k = 0; k < 64; k++) begin
         real sr = 0.0, si = 0.0, dr, di;
         int e;
         for (int n = 0; n < 64; n++) begin
            real th = 6.283185307179586 * ((n * k) % 64) / 64.0;
            real c = $cos(th), s = $sin(th);
            if (!inv_m) begin
               sr += in_re[n] * c + in_im[n] * s;
               si += in_im[n] * c - in_re[n] * s;
            end else begin
               sr += in_re[n] * c - in_im[n] * s;
               si += in_im[n] * c + in_re[n] * s;
            end
         end
         dr = got_re[k] - sr; if (dr < 0.0) dr = -dr;
         di = got_im[k] - si; if (di < 0.0) di = -di;
         e = $rtoi((dr > di ? dr : di) + 0.5);
         if (e > worst) worst = e;
      end
      return worst;
   endfunction

   task automatic run_frame(input bit inv_m, output int lat, output bit busy_seen);
      @(negedge clk);
      start   = 1'b1;
      inverse = inv_m;
      @(negedge clk);
      start = 1'b0;
      busy_seen = busy;
      lat = 0;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
   endtask

   initial begin : watchdog
      #(8 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int lat, bad, a, b;
      bit bs;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy == 1'b0, "R1", "busy during reset", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
      chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
      out_idx = 6'd37;
      #1;
      chk(out_re == '0 && out_im == '0, "R1", "slot 37 after reset", int'(out_re), 0);

      // table of frames
      for (int i = 0; i < NF; i++) begin
         make_frame(VEC[i][0], VEC[i][1], VEC[i][2]);
         load_frame();
         run_frame(VEC[i][3] != 0, lat, bs);
         chk(bs == 1'b1, "R3", "busy after start", int'(bs), 1);
         chk(lat == 48, "R6", "cycles to done", lat, 48);
         @(negedge clk);
         chk(done == 1'b0, "R6", "done width", int'(done), 0);
         read_all();
         bad = frame_err(VEC[i][3] != 0);
         chk(bad <= VEC[i][4], tag_of(i), $sformatf("frame %0d max error", i), bad, VEC[i][4]);
      end

      // R2, R3: loads and restart while busy
      make_frame(0, 0, 100);
      load_frame();
      @(negedge clk);
      start = 1'b1;
      inverse = 1'b0;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
         if (lat < 12) begin
            load_en  = 1'b1;
            load_idx = 6'(lat);
            load_re  = IN_W'(777);
            load_im  = IN_W'(-5);
         end else begin
            load_en = 1'b0;
         end
         start   = (lat == 6);
         inverse = (lat == 6);
      end
      load_en = 1'b0;
      start = 1'b0;
      inverse = 1'b0;
      chk(lat == 48, "R3", "run length with restart while busy", lat, 48);
      read_all();
      bad = 0;
      for (int k = 0; k < 64; k++)
         if (got_re[k] != 100 || got_im[k] != 0) bad++;
      chk(bad == 0, "R2", "bins disturbed by busy loads", bad, 0);

      // R9: result holds while idle
      @(negedge clk);
      out_idx = 6'd9;
      #1;
      a = int'(out_re);
      repeat (20) @(negedge clk);
      #1;
      b = int'(out_re);
      chk(a == b && b == 100, "R9", "bin 9 after idle wait", b, 100);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule